// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Instruction Decoder

This block is the test access port for a memory device's pad ring. A four-wire serial test interface (clock, mode select, data in, data out) plus an optional reset steers a sixteen-state controller. That controller shifts opcodes into an 8-bit instruction register and shifts data through one of three data registers. The data registers are a single-bit bypass stage, a 32-bit identification register and a boundary register. The boundary register holds one cell per input pin followed by one cell per output pin.

The decoded instruction selects which register sits between serial in and serial out. It also drives two controls toward the core. The first selects whether the output pads carry functional data or the boundary update stage. The second tri-states all outputs. Pads are modelled as plain vectors: `pin_in` for inputs, `core_out` for functional output values, and `pad_out`/`pad_oe` for what the pads drive.

Serial data enters at the most significant end of the selected register and leaves from bit 0. All register actions take place on the rising test clock edge. For example, capture happens on the edge that leaves Capture-DR. The serial output changes on the falling edge.

Top module: `scan_port`

## Requirements
- R1: Holding `trst_n` low at a rising edge, or entering Test-Logic-Reset through five rising edges with `tms` high, makes the identification opcode (8'h21) the active instruction. After that `out_src_bs` = 0, `out_hiz` = 0 and `pad_oe` = 1.
- R2: In Shift-IR the 8-bit instruction register forms the serial path. Capture-IR loads 8'h01, so the first two bits shifted out are 1 then 0, followed by zeros.
- R3: A shifted opcode changes the active instruction only on the rising edge that leaves Update-IR. Before that edge the controls keep their previous values.
- R4: Under opcode 8'h21, Capture-DR loads the 32-bit `ID_VALUE`, and Shift-DR shifts it out least significant bit first.
- R5: Under opcode 8'hFF, and under every code other than 8'h00, 8'h03, 8'h05, 8'h07 and 8'h21, the data path is the 1-bit bypass stage. That stage captures 0, so serial data emerges delayed by one shift.
- R6: Under opcode 8'h05, the boundary register is the data path. Capture-DR loads `{pad_out, pin_in}`, with the input cells at bits IN_W-1..0. Update-DR copies the register to the update stage. The pads keep driving `core_out`.
- R7: Under opcode 8'h00, the boundary register is the data path and `out_src_bs` = 1. `pad_out` equals the output part of the update stage and `pad_oe` = 1. Update-DR refreshes that stage.
- R8: Under opcode 8'h07, `pad_out` is held from the update stage and `pad_oe` = 1, while the bypass stage forms the data path.
- R9: Under opcode 8'h03, `pad_oe` = 0 and `out_src_bs` = 0, while the bypass stage forms the data path.
- R10: `tdo` changes only on falling test clock edges. `tdo_en` is 1 only while the controller is in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Synchronous active-low test reset |
| tms | input | 1 | Test mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling edge |
| tdo_en | output | 1 | Serial output enable |
| pin_in | input | IN_W | Input pad values |
| core_out | input | OUT_W | Functional output values from the core |
| pad_out | output | OUT_W | Values driven on the output pads |
| pad_oe | output | 1 | Output pad drive enable |
| out_src_bs | output | 1 | Output source select: 1 = boundary update stage |
| out_hiz | output | 1 | Output tri-state request |

## Verification
A table walk loads each of the six opcodes plus one reserved code. It then shifts a distinct data pattern through the selected register. The shifted-out length and content show which register is in the path: a 1-bit delay means bypass, a fixed 32-bit word means identification, and pad and pin values mean the boundary register. At the same time the pad outputs show which source drives them and whether they are enabled. The boundary pattern written under the preload opcode must later appear on the pads under the external-test and clamp opcodes, which tests update-stage retention across instruction changes. Directed sequences then separate reset by the pin from reset through the mode-select line. They also check that a shifted opcode has no effect before Update-IR, and that the serial output moves on the falling edge rather than the rising one.

// File: rtl/scan_pkg.sv
// Shared types for the test access port: controller states, opcodes,
// data-path selector and the next-state function of the controller.
package scan_pkg;

    localparam int IR_W = 8;

    localparam logic [IR_W-1:0] OP_EXTEST  = 8'h00;
    localparam logic [IR_W-1:0] OP_HIGHZ   = 8'h03;
    localparam logic [IR_W-1:0] OP_SAMPLE  = 8'h05;
    localparam logic [IR_W-1:0] OP_CLAMP   = 8'h07;
    localparam logic [IR_W-1:0] OP_IDCODE  = 8'h21;
    localparam logic [IR_W-1:0] OP_BYPASS  = 8'hFF;
    localparam logic [IR_W-1:0] IR_CAPTURE = 8'h01;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        PATH_BYP, PATH_ID, PATH_BSR
    } dr_path_e;

    // Next controller state for the current state and mode-select bit.
    function automatic tap_state_e tap_next(tap_state_e s, logic m);
        case (s)
            ST_RESET:  return m ? ST_RESET  : ST_IDLE;
            ST_IDLE:   return m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: return m ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  return m ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: return m ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: return m ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: return m ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: return m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: return m ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: return m ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  return m ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: return m ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: return m ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: return m ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: return m ? ST_SEL_DR : ST_IDLE;
            default:   return ST_RESET;
        endcase
    endfunction

endpackage

// File: rtl/tap_fsm.sv
// Sixteen-state test controller. Assumes tms is stable around the rising
// edge of tck; rst_n is a synchronous active-low reset into ST_RESET.
module tap_fsm
    import scan_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_e state
);

    // Advance the controller one step per rising test clock edge.
    always_ff @(posedge tck) begin
        if (!rst_n) state <= ST_RESET;
        else        state <= tap_next(state, tms);
    end

endmodule

// File: rtl/scan_ir.sv
// Instruction register: an 8-bit shift stage plus the active (update) stage.
// Assumes actions occur on the rising edge that leaves each controller state.
module scan_ir
    import scan_pkg::*;
(
    input  logic            tck,
    input  logic            rst_n,
    input  tap_state_e      state,
    input  logic            tdi,
    output logic            ir_so,
    output logic [IR_W-1:0] ir_active
);

    logic [IR_W-1:0] ir_sr;

    // Capture the fixed pattern, then shift serial data toward bit 0.
    always_ff @(posedge tck) begin
        if (!rst_n)                 ir_sr <= '0;
        else if (state == ST_CAP_IR) ir_sr <= IR_CAPTURE;
        else if (state == ST_SH_IR)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end

    // Commit the shifted opcode on Update-IR; fall back to the ID opcode in reset.
    always_ff @(posedge tck) begin
        if (!rst_n)                  ir_active <= OP_IDCODE;
        else if (state == ST_RESET)  ir_active <= OP_IDCODE;
        else if (state == ST_UPD_IR) ir_active <= ir_sr;
    end

    assign ir_so = ir_sr[0];

endmodule

// File: rtl/scan_dr.sv
// Data registers: bypass bit, identification word, boundary register and
// its update stage. Input cells occupy bits IN_W-1..0, output cells above.
module scan_dr
    import scan_pkg::*;
#(
    parameter int          IN_W     = 4,
    parameter int          OUT_W    = 4,
    parameter logic [31:0] ID_VALUE = 32'h1A5C_30E1,
    localparam int         BS_LEN   = IN_W + OUT_W
)(
    input  logic              tck,
    input  logic              rst_n,
    input  tap_state_e        state,
    input  dr_path_e          path,
    input  logic              upd_en,
    input  logic              tdi,
    input  logic [IN_W-1:0]   pin_in,
    input  logic [OUT_W-1:0]  pad_obs,
    output logic              dr_so,
    output logic [BS_LEN-1:0] bs_upd
);

    logic              byp_q;
    logic [31:0]       id_q;
    logic [BS_LEN-1:0] bs_q;

    // Bypass stage: capture zero, shift one bit.
    always_ff @(posedge tck) begin
        if (!rst_n)                                         byp_q <= 1'b0;
        else if (state == ST_CAP_DR && path == PATH_BYP)    byp_q <= 1'b0;
        else if (state == ST_SH_DR && path == PATH_BYP)     byp_q <= tdi;
    end

    // Identification word: capture the constant, shift toward bit 0.
    always_ff @(posedge tck) begin
        if (!rst_n)                                         id_q <= '0;
        else if (state == ST_CAP_DR && path == PATH_ID)     id_q <= ID_VALUE;
        else if (state == ST_SH_DR && path == PATH_ID)      id_q <= {tdi, id_q[31:1]};
    end

    // Boundary register: capture pad and pin values, shift toward bit 0.
    always_ff @(posedge tck) begin
        if (!rst_n)                                         bs_q <= '0;
        else if (state == ST_CAP_DR && path == PATH_BSR)    bs_q <= {pad_obs, pin_in};
        else if (state == ST_SH_DR && path == PATH_BSR)     bs_q <= {tdi, bs_q[BS_LEN-1:1]};
    end

    // Update stage: hold the boundary contents seen at Update-DR.
    always_ff @(posedge tck) begin
        if (!rst_n)                                bs_upd <= '0;
        else if (state == ST_UPD_DR && upd_en)     bs_upd <= bs_q;
    end

    // Serial output of the selected data register.
    always_comb begin
        case (path)
            PATH_ID:  dr_so = id_q[0];
            PATH_BSR: dr_so = bs_q[0];
            default:  dr_so = byp_q;
        endcase
    end

endmodule

// File: rtl/scan_port.sv
// Top of the test access port. Decodes the active opcode into a data-path
// choice and the two output controls, muxes the pads, and retimes the serial
// output to the falling edge. Assumes one test clock domain for all logic.
module scan_port
    import scan_pkg::*;
#(
    parameter int          IN_W     = 4,
    parameter int          OUT_W    = 4,
    parameter logic [31:0] ID_VALUE = 32'h1A5C_30E1,
    localparam int         BS_LEN   = IN_W + OUT_W
)(
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tms,
    input  logic             tdi,
    output logic             tdo,
    output logic             tdo_en,
    input  logic [IN_W-1:0]  pin_in,
    input  logic [OUT_W-1:0] core_out,
    output logic [OUT_W-1:0] pad_out,
    output logic             pad_oe,
    output logic             out_src_bs,
    output logic             out_hiz
);

    tap_state_e        st;
    logic [IR_W-1:0]   ir_active;
    logic              ir_so;
    logic              dr_so;
    dr_path_e          path;
    logic              upd_en;
    logic [BS_LEN-1:0] bs_upd;
    logic              shifting;
    logic              so_sel;

    tap_fsm u_fsm (
        .tck   (tck),
        .rst_n (trst_n),
        .tms   (tms),
        .state (st)
    );

    scan_ir u_ir (
        .tck       (tck),
        .rst_n     (trst_n),
        .state     (st),
        .tdi       (tdi),
        .ir_so     (ir_so),
        .ir_active (ir_active)
    );

    scan_dr #(
        .IN_W     (IN_W),
        .OUT_W    (OUT_W),
        .ID_VALUE (ID_VALUE)
    ) u_dr (
        .tck     (tck),
        .rst_n   (trst_n),
        .state   (st),
        .path    (path),
        .upd_en  (upd_en),
        .tdi     (tdi),
        .pin_in  (pin_in),
        .pad_obs (pad_out),
        .dr_so   (dr_so),
        .bs_upd  (bs_upd)
    );

    // Decode the active opcode; unknown codes fall back to bypass.
    always_comb begin
        path       = PATH_BYP;
        upd_en     = 1'b0;
        out_src_bs = 1'b0;
        out_hiz    = 1'b0;
        case (ir_active)
            OP_EXTEST: begin path = PATH_BSR; upd_en = 1'b1; out_src_bs = 1'b1; end
            OP_SAMPLE: begin path = PATH_BSR; upd_en = 1'b1; end
            OP_CLAMP:  out_src_bs = 1'b1;
            OP_HIGHZ:  out_hiz = 1'b1;
            OP_IDCODE: path = PATH_ID;
            default:   path = PATH_BYP;
        endcase
    end

    // Per-pin output source: boundary update cell or functional value.
    for (genvar i = 0; i < OUT_W; i++) begin : g_pad
        assign pad_out[i] = out_src_bs ? bs_upd[IN_W+i] : core_out[i];
    end

    assign pad_oe   = ~out_hiz;
    assign shifting = (st == ST_SH_IR) || (st == ST_SH_DR);
    assign so_sel   = (st == ST_SH_IR) ? ir_so : dr_so;

    // Retime serial output and its enable to the falling edge.
    always_ff @(negedge tck) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo    <= shifting ? so_sel : 1'b0;
            tdo_en <= shifting;
        end
    end

endmodule

// File: rtl/scan_port_chk.sv
// Protocol checker for scan_port, attached by bind. Observes the controller
// state and the output controls; holds no design state of its own.
module scan_port_chk
    import scan_pkg::*;
(
    input logic       tck,
    input logic       trst_n,
    input tap_state_e state,
    input logic       tdo_en,
    input logic       out_src_bs,
    input logic       out_hiz,
    input logic       pad_oe
);

    AST_RESET_RELEASE: assert property (@(posedge tck) disable iff (!trst_n)
        $rose(trst_n) |-> (!out_src_bs && !out_hiz && pad_oe)); // R1

    AST_RESET_STATE_ID: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_RESET) |=> (!out_src_bs && !out_hiz)); // R1

    AST_CTRL_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
        (state != ST_UPD_IR && state != ST_RESET) |=> ($stable(out_src_bs) && $stable(out_hiz))); // R3

    AST_SRC_DRIVES: assert property (@(posedge tck) disable iff (!trst_n)
        out_src_bs |-> pad_oe); // R7

    AST_CTRL_EXCL: assert property (@(posedge tck) disable iff (!trst_n)
        $onehot0({out_src_bs, out_hiz})); // R9

    AST_TDO_EN_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en |-> (state == ST_SH_IR || state == ST_SH_DR)); // R10

endmodule

bind scan_port scan_port_chk u_chk (
    .tck        (tck),
    .trst_n     (trst_n),
    .state      (st),
    .tdo_en     (tdo_en),
    .out_src_bs (out_src_bs),
    .out_hiz    (out_hiz),
    .pad_oe     (pad_oe)
);

// File: tb/scan_port_tb.sv
// Self-checking bench: a table walk over the opcodes, then directed cases.
module scan_port_tb;

    localparam int          PER   = 20;
    localparam int          IN_W  = 4;
    localparam int          OUT_W = 4;
    localparam int          BSL   = IN_W + OUT_W;
    localparam logic [31:0] IDV   = 32'h1A5C_30E1;
    localparam logic [IN_W-1:0]  PIN  = 4'hA;
    localparam logic [OUT_W-1:0] CORE = 4'h6;

    // {opcode, kind (0 bypass, 1 id, 2 boundary), expect src_bs, expect hiz}
    localparam logic [11:0] VEC [0:6] = '{
        {8'h05, 2'd2, 1'b0, 1'b0},
        {8'h00, 2'd2, 1'b1, 1'b0},
        {8'h07, 2'd0, 1'b1, 1'b0},
        {8'h03, 2'd0, 1'b0, 1'b1},
        {8'h21, 2'd1, 1'b0, 1'b0},
        {8'hFF, 2'd0, 1'b0, 1'b0},
        {8'h5A, 2'd0, 1'b0, 1'b0}
    };

    logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic tdo, tdo_en, pad_oe, out_src_bs, out_hiz;
    logic [IN_W-1:0]  pin_in   = PIN;
    logic [OUT_W-1:0] core_out = CORE;
    logic [OUT_W-1:0] pad_out;
    int total = 0, bad = 0;
    logic [BSL-1:0] exp_upd = '0;

    scan_port #(.IN_W(IN_W), .OUT_W(OUT_W), .ID_VALUE(IDV)) u_dut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
        .pin_in(pin_in), .core_out(core_out), .pad_out(pad_out), .pad_oe(pad_oe),
        .out_src_bs(out_src_bs), .out_hiz(out_hiz)
    );

    always #(PER/2) tck = ~tck;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One test clock: read tdo, drive inputs, pass a rising and falling edge.
    task automatic step(input logic m, input logic d, output logic o);
        o = tdo; tms = m; tdi = d;
        @(posedge tck); @(negedge tck); #1;
    endtask

    task automatic shift_ir_to_exit(input logic [7:0] op, output logic [7:0] cap);
        logic o;
        step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
        for (int i = 0; i < 8; i++) begin step(i == 7, op[i], o); cap[i] = o; end
    endtask

    task automatic load_ir(input logic [7:0] op, output logic [7:0] cap);
        logic o;
        shift_ir_to_exit(op, cap);
        step(1, 0, o); step(0, 0, o);
    endtask

    task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
        logic o;
        dout = '0;
        step(1, 0, o); step(0, 0, o); step(0, 0, o);
        for (int i = 0; i < n; i++) begin step(i == n-1, din[i], o); dout[i] = o; end
        step(1, 0, o); step(0, 0, o);
    endtask

    function automatic string tag_of(input logic [7:0] op);
        case (op)
            8'h00: return "R7";
            8'h03: return "R9";
            8'h05: return "R6";
            8'h07: return "R8";
            8'h21: return "R4";
            default: return "R5";
        endcase
    endfunction

    initial begin
        #(PER*100000);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic o;
        logic [7:0] cap;
        logic [63:0] dout, din, expv, mask;
        logic [OUT_W-1:0] exp_pad;
        int n;

        @(negedge tck); #1;
        step(1, 0, o); step(1, 0, o);
        trst_n = 1'b1;
        step(0, 0, o);
        // R1: state after pin reset
        check("R1 reset src_bs", out_src_bs, 0);
        check("R1 reset hiz", out_hiz, 0);
        check("R1 reset oe", pad_oe, 1);
        check("R10 reset tdo_en", tdo_en, 0);
        // R4: identification word right after reset
        scan_dr(32, 64'h0, dout);
        check("R4 id after reset", dout[31:0], IDV);

        // Table walk over opcodes
        for (int k = 0; k < 7; k++) begin
            logic [7:0] op;
            logic [1:0] kind;
            logic bs, hz;
            {op, kind, bs, hz} = VEC[k];
            load_ir(op, cap);
            check("R2 ir capture", cap, 8'h01);
            check({tag_of(op), " src_bs"}, out_src_bs, bs);
            check({tag_of(op), " oe"}, pad_oe, !hz);
            exp_pad = bs ? exp_upd[BSL-1:IN_W] : CORE;
            check({tag_of(op), " pad_out"}, pad_out, exp_pad);
            din = 64'hC3A5_0F96_5AA5_3C71 >> (k * 5);
            n = (kind == 2'd0) ? 8 : (kind == 2'd1) ? 32 : BSL;
            scan_dr(n, din, dout);
            mask = (64'h1 << n) - 1;
            if (kind == 2'd0)      expv = {din[62:0], 1'b0} & mask;
            else if (kind == 2'd1) expv = {32'h0, IDV};
            else                   expv = {56'h0, exp_pad, PIN};
            check({tag_of(op), " scan path"}, dout & mask, expv);
            if (op == 8'h00 || op == 8'h05) exp_upd = din[BSL-1:0];
            exp_pad = bs ? exp_upd[BSL-1:IN_W] : CORE;
            check({tag_of(op), " pad after update"}, pad_out, exp_pad);
        end

        // R3: opcode has no effect before Update-IR
        shift_ir_to_exit(8'h03, cap);
        check("R3 hiz in exit-ir", out_hiz, 0);
        step(1, 0, o);
        check("R3 hiz in update-ir", out_hiz, 0);
        step(0, 0, o);
        check("R9 hiz after update", out_hiz, 1);
        check("R9 oe after update", pad_oe, 0);

        // R1: five high tms cycles return to the ID opcode
        for (int i = 0; i < 5; i++) step(1, 0, o);
        check("R1 tms reset hiz", out_hiz, 0);
        step(0, 0, o);
        scan_dr(32, 64'h0, dout);
        check("R1 tms reset id path", dout[31:0], IDV);

        // R10: tdo moves on the falling edge only
        load_ir(8'hFF, cap);
        step(1, 0, o); step(0, 0, o); step(0, 0, o);
        check("R10 tdo_en in shift", tdo_en, 1);
        check("R10 tdo captured bypass", tdo, 0);
        tms = 1'b0; tdi = 1'b1;
        @(posedge tck); #1;
        check("R10 tdo held after rise", tdo, 0);
        @(negedge tck); #1;
        check("R10 tdo after fall", tdo, 1);
        step(1, 0, o); step(1, 0, o); step(0, 0, o);
        check("R10 tdo_en idle", tdo_en, 0);

        // R1: pin reset clears clamp drive
        load_ir(8'h07, cap);
        check("R8 clamp src", out_src_bs, 1);
        trst_n = 1'b0;
        step(1, 0, o);
        trst_n = 1'b1;
        step(0, 0, o);
        check("R1 pin reset src", out_src_bs, 0);
        check("R1 pin reset pad", pad_out, CORE);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule